// File: doc/BRIEF.md
# Sample-Memory Waveform Player

This block keeps a short waveform of eight-bit samples in on-chip memory and replays it, sample after sample, into two DAC output registers at a rate set by software. A command decoder in front of it turns command words into one-cycle pulses: clear the sample pointer, store one sample, write one byte of the step period, start or stop playback with a routing choice, and a plain stop. The decoder, the direct-DAC path and the analog side live elsewhere.

Samples are loaded through a single-byte port whose pointer advances after every store, so a pointer clear followed by one store per entry fills the whole memory. The step period is a wide register written one byte at a time through a two-bit selector. During playback a countdown timer, clocked by a tick enable derived from the system clock, reloads from the period register each time it expires. On each expiry the next sample is read from memory and sent to DAC A, DAC B, or both. When the last entry has been played, the player moves on to entry 0 with no gap. While the player is idle it drives zero on both outputs and keeps its playing flag low, so the downstream multiplexer can hand the DACs to the direct path.

Top module: `ramwave_player`

## Requirements
- R1: A pointer-clear pulse sets the sample pointer to 0. Each store pulse writes `data_i` at the pointer and then advances the pointer by one, wrapping from DEPTH-1 to 0.
- R2: A period-write pulse copies `data_i` into one byte of the period register. Selector 00 selects bits 7:0, 01 selects bits 15:8 and 10 selects bits 23:16. The other bytes keep their values. Selector 11 changes nothing.
- R3: During playback the countdown steps once per tick, and a tick occurs every TICK_DIV clock cycles. On expiry it reloads the period value P, so consecutive samples are TICK_DIV*(P+1) cycles apart. With P = 0 the player advances one sample per tick.
- R4: A route pulse with a nonzero selector starts playback. `playing_o` goes high on the clock edge that samples the pulse. The sample at the current pointer appears on the selected outputs one edge later, and sample n appears 1 + n*TICK_DIV*(P+1) edges after the start edge.
- R5: Route selector 01 sends samples to DAC A only, 10 to DAC B only and 11 to both. An unselected output holds 0 during playback.
- R6: After entry DEPTH-1 the player plays entry 0 at the same spacing, with no zero or repeated sample in between.
- R7: A route pulse with selector 00 stops playback. Both outputs are 0 and `playing_o` is low after that edge.
- R8: A stop pulse ends playback at once. Both outputs are 0 and `playing_o` is low after that edge.
- R9: While the player is idle, including right after reset, both outputs are 0 and `playing_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_clr_i | input | 1 | Pulse: sample pointer to 0 |
| store_i | input | 1 | Pulse: write data_i at the pointer, then advance the pointer |
| per_wr_i | input | 1 | Pulse: write data_i into the period byte picked by sel_i |
| route_i | input | 1 | Pulse: start playback to the outputs picked by sel_i (00 stops) |
| halt_i | input | 1 | Pulse: stop playback |
| sel_i | input | 2 | Byte or route selector for the current pulse |
| data_i | input | DATA_W | Sample or period byte |
| dac_a_o | output | DATA_W | DAC A value |
| dac_b_o | output | DATA_W | DAC B value |
| playing_o | output | 1 | High while playback owns the DACs |

## Verification
The bench builds the player with DEPTH = 8 and TICK_DIV = 2, and leaves DATA_W and PERIOD_W at 8 and 24. An eight-entry memory makes the wrap from the last entry to entry 0 appear within about ten samples, so the continuity of R6 is checked on every stimulus vector. The two-cycle tick keeps short periods to a few cycles, and a middle-byte period of 256 is still cheap to run. A top-byte write makes the period so long that the bench only confirms that the first sample stays on the output through a long window.

// File: rtl/rw_pkg.sv
package rw_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_A    = 2'b01,
      ROUTE_B    = 2'b10,
      ROUTE_AB   = 2'b11
   } route_e;

   localparam int unsigned MAX_PERIOD_LANES = 3;

endpackage

// File: rtl/rw_tick_gen.sv
module rw_tick_gen #(
   parameter int unsigned TICK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);

   generate
      if (TICK_DIV <= 1) begin : g_every_cycle
         assign tick_o = 1'b1;
      end else begin : g_divided
         localparam int unsigned CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart_i || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/rw_period_timer.sv
module rw_period_timer #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PERIOD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per_wr_i,
   input  logic [1:0]        sel_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              load_i,
   input  logic              run_i,
   input  logic              tick_i,
   output logic              step_o
);

   localparam int unsigned LANES = PERIOD_W / DATA_W;

   logic [PERIOD_W-1:0] period_q;
   logic [PERIOD_W-1:0] count_q;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               period_q[g*DATA_W +: DATA_W] <= '0;
            end else if (per_wr_i && sel_i == 2'(g)) begin
               period_q[g*DATA_W +: DATA_W] <= data_i;
            end
         end
      end
   endgenerate

   assign step_o = run_i && tick_i && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= period_q;
      end else if (run_i && tick_i) begin
         if (count_q == '0) begin
            count_q <= period_q;
         end else begin
            count_q <= count_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/rw_sample_ram.sv
module rw_sample_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 512
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic                     re_i,
   input  logic [$clog2(DEPTH)-1:0] addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem_q[addr_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (re_i) begin
         rdata_o <= mem_q[addr_i];
      end
   end

endmodule

// File: rtl/ramwave_player.sv
module ramwave_player #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DEPTH    = 512,
   parameter int unsigned PERIOD_W = 24,
   parameter int unsigned TICK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_clr_i,
   input  logic              store_i,
   input  logic              per_wr_i,
   input  logic              route_i,
   input  logic              halt_i,
   input  logic [1:0]        sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] dac_a_o,
   output logic [DATA_W-1:0] dac_b_o,
   output logic              playing_o
);

   import rw_pkg::*;

   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned LANES = PERIOD_W / DATA_W;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (PERIOD_W % DATA_W != 0 || LANES < 1 || LANES > MAX_PERIOD_LANES) begin : g_bad_period
         $error("PERIOD_W must be 1 to 3 whole bytes of DATA_W");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic          start;
   logic          stop;
   logic          tick;
   logic          step;
   logic          fetch;
   logic          rd_vld_q;
   logic [AW-1:0] ptr_q;
   route_e        route_q;
   logic [DATA_W-1:0] rd_data;

   assign start = route_i && (sel_i != ROUTE_NONE) && !halt_i;
   assign stop  = halt_i || (route_i && sel_i == ROUTE_NONE);
   assign fetch = (start || step) && !stop;

   rw_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (start),
      .tick_o    (tick)
   );

   rw_period_timer #(
      .DATA_W   (DATA_W),
      .PERIOD_W (PERIOD_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .per_wr_i (per_wr_i),
      .sel_i    (sel_i),
      .data_i   (data_i),
      .load_i   (start),
      .run_i    (playing_o && !stop && !start),
      .tick_i   (tick),
      .step_o   (step)
   );

   rw_sample_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ram (
      .clk     (clk),
      .we_i    (store_i && !ptr_clr_i),
      .re_i    (fetch),
      .addr_i  (ptr_q),
      .wdata_i (data_i),
      .rdata_o (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_clr_i) begin
         ptr_q <= '0;
      end else if (store_i || fetch) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         playing_o <= 1'b0;
         route_q   <= ROUTE_NONE;
         rd_vld_q  <= 1'b0;
      end else begin
         rd_vld_q <= fetch;
         if (stop) begin
            playing_o <= 1'b0;
         end else if (start) begin
            playing_o <= 1'b1;
            route_q   <= route_e'(sel_i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_a_o <= '0;
         dac_b_o <= '0;
      end else if (stop) begin
         dac_a_o <= '0;
         dac_b_o <= '0;
      end else if (rd_vld_q && playing_o) begin
         dac_a_o <= route_q[0] ? rd_data : '0;
         dac_b_o <= route_q[1] ? rd_data : '0;
      end
   end

endmodule

// File: rtl/rw_player_checker.sv
module rw_player_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              route_i,
   input logic              halt_i,
   input logic [1:0]        sel_i,
   input logic [DATA_W-1:0] dac_a_o,
   input logic [DATA_W-1:0] dac_b_o,
   input logic              playing_o,
   input logic              rd_vld_q
);

   logic [1:0] seen_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_sel_q <= 2'b00;
      end else if (route_i && !halt_i && sel_i != 2'b00) begin
         seen_sel_q <= sel_i;
      end
   end

   a_r8_stop_halts : assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (!playing_o && dac_a_o == '0 && dac_b_o == '0));

   a_r7_route_none_halts : assert property (@(posedge clk) disable iff (!rst_n)
      (route_i && sel_i == 2'b00) |=> (!playing_o && dac_a_o == '0 && dac_b_o == '0));

   a_r9_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !playing_o |-> (dac_a_o == '0 && dac_b_o == '0));

   a_r4_start_plays : assert property (@(posedge clk) disable iff (!rst_n)
      (route_i && !halt_i && sel_i != 2'b00) |=> playing_o);

   a_r5_unselected_b_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (playing_o && seen_sel_q == 2'b01) |-> dac_b_o == '0);

   a_r5_unselected_a_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (playing_o && seen_sel_q == 2'b10) |-> dac_a_o == '0);

   a_r3_update_after_read : assert property (@(posedge clk) disable iff (!rst_n)
      (playing_o && $past(playing_o) && !$stable(dac_a_o)) |-> $past(rd_vld_q));

endmodule

bind ramwave_player rw_player_checker #(
   .DATA_W (DATA_W)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .route_i   (route_i),
   .halt_i    (halt_i),
   .sel_i     (sel_i),
   .dac_a_o   (dac_a_o),
   .dac_b_o   (dac_b_o),
   .playing_o (playing_o),
   .rd_vld_q  (rd_vld_q)
);

// File: tb/ramwave_player_tb.sv
module ramwave_player_tb;

   localparam int unsigned DW    = 8;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned DIV   = 2;
   localparam int unsigned NSAMP = DEPTH + 2;

   // vector: period[17:2] (low two bytes), route selector [1:0]
   localparam logic [17:0] VEC [5] = '{
      {16'd0,   2'b01},
      {16'd1,   2'b10},
      {16'd3,   2'b11},
      {16'd2,   2'b01},
      {16'd256, 2'b11}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ptr_clr_i = 1'b0;
   logic          store_i = 1'b0;
   logic          per_wr_i = 1'b0;
   logic          route_i = 1'b0;
   logic          halt_i = 1'b0;
   logic [1:0]    sel_i = 2'b00;
   logic [DW-1:0] data_i = '0;
   logic [DW-1:0] dac_a_o;
   logic [DW-1:0] dac_b_o;
   logic          playing_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [DW-1:0] ref_mem [DEPTH];

   always #10 clk = ~clk;

   ramwave_player #(
      .DATA_W   (DW),
      .DEPTH    (DEPTH),
      .PERIOD_W (24),
      .TICK_DIV (DIV)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_clr_i (ptr_clr_i),
      .store_i   (store_i),
      .per_wr_i  (per_wr_i),
      .route_i   (route_i),
      .halt_i    (halt_i),
      .sel_i     (sel_i),
      .data_i    (data_i),
      .dac_a_o   (dac_a_o),
      .dac_b_o   (dac_b_o),
      .playing_o (playing_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d, expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // one-cycle command pulse; returns at the falling edge after the sampling edge
   task automatic cmd(input logic clr, input logic st, input logic pw, input logic rt,
                      input logic hl, input logic [1:0] s, input logic [DW-1:0] d);
      @(negedge clk);
      ptr_clr_i = clr; store_i = st; per_wr_i = pw; route_i = rt; halt_i = hl;
      sel_i = s; data_i = d;
      @(negedge clk);
      ptr_clr_i = 1'b0; store_i = 1'b0; per_wr_i = 1'b0; route_i = 1'b0; halt_i = 1'b0;
      sel_i = 2'b00; data_i = '0;
   endtask

   task automatic set_period(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
      cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, lo);
      cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, mid);
      cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, hi);
      // R2: selector 11 must leave all three bytes alone
      cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'hFF);
   endtask

   task automatic expect_outs(input string req, input logic [1:0] s, input logic [DW-1:0] v);
      check({req, " dac_a"}, int'(dac_a_o), s[0] ? int'(v) : 0);
      check({req, " dac_b"}, int'(dac_b_o), s[1] ? int'(v) : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'((i * 37 + 5) & 8'hFF);

      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 reset dac_a", int'(dac_a_o), 0);
      check("R9 reset dac_b", int'(dac_b_o), 0);
      check("R9 reset playing", int'(playing_o), 0);
      rst_n = 1'b1;

      // R1: fill memory from pointer 0
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0);
      for (int i = 0; i < DEPTH; i++) cmd(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, ref_mem[i]);

      // R2: top byte moves the period out of a 600-cycle window
      set_period(8'd0, 8'd0, 8'd1);
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0);
      cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, '0);
      check("R4 playing after start", int'(playing_o), 1);
      @(negedge clk);
      expect_outs("R1 first sample", 2'b01, ref_mem[0]);
      repeat (600) @(negedge clk);
      expect_outs("R2 top byte holds sample", 2'b01, ref_mem[0]);

      // R7: route selector 00 stops and zeroes
      cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, '0);
      check("R7 playing low", int'(playing_o), 0);
      expect_outs("R7 zero outputs", 2'b00, '0);

      // table of vectors
      for (int v = 0; v < 5; v++) begin
         logic [15:0] per;
         logic [1:0]  rs;
         int cur;
         int step;
         per  = VEC[v][17:2];
         rs   = VEC[v][1:0];
         step = DIV * (int'(per) + 1);
         set_period(per[7:0], per[15:8], 8'd0);
         cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0);
         cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, rs, '0);
         check("R4 playing", int'(playing_o), 1);
         cur = 0;
         for (int n = 0; n < NSAMP; n++) begin
            int t;
            t = 1 + n * step;
            if (n > 0) begin
               repeat (t - 1 - cur) @(negedge clk);
               cur = t - 1;
               // R3 and R6: previous sample still shown one cycle before the step
               expect_outs("R3 hold before step", rs, ref_mem[(n - 1) % DEPTH]);
            end
            repeat (t - cur) @(negedge clk);
            cur = t;
            // R5 routing, R6 wrap continuity, R3 spacing
            expect_outs(n >= DEPTH ? "R6 wrap sample" : "R5 routed sample",
                        rs, ref_mem[n % DEPTH]);
         end
         // R8: stop pulse
         cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, '0);
         check("R8 playing low", int'(playing_o), 0);
         expect_outs("R8 zero outputs", 2'b00, '0);
         repeat (4) @(negedge clk);
         expect_outs("R9 idle stays zero", 2'b00, '0);
      end

      // R1: pointer wraps after DEPTH stores; one extra store overwrites entry 0
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0);
      for (int i = 0; i <= DEPTH; i++) begin
         logic [DW-1:0] d;
         d = (i == DEPTH) ? 8'hC3 : ref_mem[i];
         cmd(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, d);
      end
      ref_mem[0] = 8'hC3;
      set_period(8'd0, 8'd0, 8'd0);
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0);
      cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, '0);
      @(negedge clk);
      expect_outs("R1 wrapped store", 2'b10, 8'hC3);
      @(negedge clk);
      @(negedge clk);
      expect_outs("R3 zero period one per tick", 2'b10, ref_mem[1]);
      cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, '0);
      check("R8 final stop", int'(playing_o), 0);

      finish_run();
   end

endmodule